// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns an operand description into the effective address that an 8-bit processor instruction uses. Each calculation starts with a one-cycle `start` pulse. On that cycle the unit samples a 4-bit addressing-mode code, the one or two operand bytes that follow the opcode, and the X and Y index registers. Modes that need no memory access finish on the next cycle. The three indirect modes fetch a 16-bit pointer one byte at a time, low byte first, through a byte-wide read port that uses a request/valid handshake. When the address is ready the unit raises `done` for one cycle. In that cycle it also shows the address, a page-cross flag, and an immediate flag for the case where the operand byte is the data itself.

The sequencer has four states. IDLE waits for `start`. FETCH_LO requests the pointer's low byte. FETCH_HI requests its high byte. FINISH presents the result. The transitions are:
- IDLE to FINISH on `start` with a direct mode.
- IDLE to FETCH_LO on `start` with an indirect mode.
- FETCH_LO to FETCH_HI on `mem_valid`.
- FETCH_HI to FINISH on `mem_valid`.
- FINISH to IDLE unconditionally.

Every other condition holds the current state.

Top module: `eag_unit`

## Requirements
- R1: Mode code 0 (immediate): `done` is high on the cycle after the `start` edge, with `is_imm`=1 and `ea`=0x0000. No memory read is made.
- R2: Mode code 1 (absolute) gives `ea` = {`opnd_hi`,`opnd_lo`}, with `done` on the cycle after `start`. Codes 10 to 15 behave the same way.
- R3: Mode code 2 (zero page) gives `ea` = {0x00,`opnd_lo`}.
- R4: Mode codes 3 and 4 (absolute plus X, absolute plus Y) give `ea` = ({`opnd_hi`,`opnd_lo`} + index) mod 0x10000. `page_cross` is 1 exactly when the high byte of `ea` differs from `opnd_hi`.
- R5: Mode codes 5 and 6 (zero page plus X, zero page plus Y) give `ea` = {0x00, (`opnd_lo` + index) mod 256}, with `page_cross`=0.
- R6: Mode code 7 (index before pointer) reads address {0x00,(`opnd_lo`+X) mod 256} and then {0x00,(`opnd_lo`+X+1) mod 256}. `ea` is {second byte, first byte}.
- R7: Mode code 8 (index after pointer) reads {0x00,`opnd_lo`} and then {0x00,(`opnd_lo`+1) mod 256}. `ea` = (pointer + Y) mod 0x10000, and `page_cross` is 1 when the high byte of `ea` differs from the pointer's high byte.
- R8: Mode code 9 (pure indirect, for jumps) reads {`opnd_hi`,`opnd_lo`} and then that address plus 1 (16-bit). `ea` is the fetched pointer.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_valid` is sampled high. An indirect calculation with L wait cycles per byte has `done` high 2L+3 cycles after the `start` edge.
- R10: `done` is high for exactly one cycle per accepted `start`. `is_imm` and `page_cross` are high only with `done`. A `start` or an input change while a calculation is in progress has no effect on its result.
- R11: While `rst_n` is low, `done`, `mem_req`, `is_imm` and `page_cross` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (accepted in IDLE only) |
| mode | input | 4 | Addressing-mode code |
| opnd_lo | input | 8 | First operand byte after the opcode |
| opnd_hi | input | 8 | Second operand byte after the opcode |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| mem_req | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte read address |
| mem_rdata | input | 8 | Read data |
| mem_valid | input | 1 | Read data valid |
| done | output | 1 | Result strobe, one cycle |
| ea | output | 16 | Effective address, valid with done |
| is_imm | output | 1 | Operand is immediate data, valid with done |
| page_cross | output | 1 | Indexed sum changed the high byte, valid with done |

## Verification
The assertions watch, on every cycle, several properties. They check the one-cycle `done` pulse and that a pending request holds its address. They check that the result flags appear only with `done`, and that the immediate result carries a zero address. They also check that zero-page results and zero-page pointer reads never leave page zero, and that a page crossing is reported only by the three modes that add an index to a 16-bit base. Only the bench scenarios can show the arithmetic itself. That covers the exact sums and their wrap points at 0xFF and 0xFFFF, the pointer byte order, and the order of the two read addresses. It also covers the latency against the wait cycles and the fact that a second `start` during a fetch is ignored.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;

    typedef enum logic [3:0] {
        AM_IMM  = 4'd0,
        AM_ABS  = 4'd1,
        AM_ZPG  = 4'd2,
        AM_ABX  = 4'd3,
        AM_ABY  = 4'd4,
        AM_ZPX  = 4'd5,
        AM_ZPY  = 4'd6,
        AM_PRE  = 4'd7,
        AM_POST = 4'd8,
        AM_IND  = 4'd9
    } amode_t;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_FETCH_LO = 2'd1,
        S_FETCH_HI = 2'd2,
        S_FINISH   = 2'd3
    } seq_state_t;

    function automatic logic needs_ptr(input logic [3:0] m);
        return (m == AM_PRE) || (m == AM_POST) || (m == AM_IND);
    endfunction
endpackage

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
    import eag_pkg::*;
(
    input  amode_t          mode_q,
    input  logic [AW-1:0]   opnd_q,
    input  logic [DW-1:0]   x_q,
    input  logic [DW-1:0]   y_q,
    input  logic [AW-1:0]   ptr_q,
    output logic [AW-1:0]   rd_addr0,
    output logic [AW-1:0]   rd_addr1,
    output logic [AW-1:0]   ea_c,
    output logic            cross_c,
    output logic            imm_c
);
    localparam logic [DW-1:0] ZPAGE = '0;

    logic [DW-1:0] idx;
    logic [AW-1:0] base;
    logic [AW-1:0] full_sum;
    logic [DW-1:0] zp_sum;
    logic [DW-1:0] zp_next;

    always_comb begin
        idx = (mode_q == AM_ABY || mode_q == AM_ZPY || mode_q == AM_POST) ? y_q : x_q;
        base     = (mode_q == AM_POST) ? ptr_q : opnd_q;
        full_sum = base + {ZPAGE, idx};
        zp_sum   = opnd_q[DW-1:0] + idx;
        zp_next  = zp_sum + 1'b1;
    end

    always_comb begin
        rd_addr0 = opnd_q;
        rd_addr1 = opnd_q + 1'b1;
        ea_c     = opnd_q;
        cross_c  = 1'b0;
        imm_c    = 1'b0;
        unique case (mode_q)
            AM_IMM: begin
                ea_c  = '0;
                imm_c = 1'b1;
            end
            AM_ZPG: ea_c = {ZPAGE, opnd_q[DW-1:0]};
            AM_ABX, AM_ABY: begin
                ea_c    = full_sum;
                cross_c = (full_sum[AW-1:DW] != base[AW-1:DW]);
            end
            AM_ZPX, AM_ZPY: ea_c = {ZPAGE, zp_sum};
            AM_PRE: begin
                rd_addr0 = {ZPAGE, zp_sum};
                rd_addr1 = {ZPAGE, zp_next};
                ea_c     = ptr_q;
            end
            AM_POST: begin
                rd_addr0 = {ZPAGE, opnd_q[DW-1:0]};
                rd_addr1 = {ZPAGE, opnd_q[DW-1:0] + 1'b1};
                ea_c     = full_sum;
                cross_c  = (full_sum[AW-1:DW] != base[AW-1:DW]);
            end
            AM_IND: ea_c = ptr_q;
            default: ea_c = opnd_q;
        endcase
    end
endmodule

// File: rtl/eag_fsm.sv
module eag_fsm
    import eag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ptr_mode,
    input  logic mem_valid,
    output logic load,
    output logic cap_lo,
    output logic cap_hi,
    output logic mem_req,
    output logic use_hi,
    output logic done
);
    seq_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start) state_nx = ptr_mode ? S_FETCH_LO : S_FINISH;
            S_FETCH_LO: if (mem_valid) state_nx = S_FETCH_HI;
            S_FETCH_HI: if (mem_valid) state_nx = S_FINISH;
            S_FINISH:   state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        load    = (state == S_IDLE) && start;
        mem_req = (state == S_FETCH_LO) || (state == S_FETCH_HI);
        use_hi  = (state == S_FETCH_HI);
        cap_lo  = (state == S_FETCH_LO) && mem_valid;
        cap_hi  = (state == S_FETCH_HI) && mem_valid;
        done    = (state == S_FINISH);
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [7:0]    opnd_lo,
    input  logic [7:0]    opnd_hi,
    input  logic [7:0]    idx_x,
    input  logic [7:0]    idx_y,
    output logic          mem_req,
    output logic [15:0]   mem_addr,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_valid,
    output logic          done,
    output logic [15:0]   ea,
    output logic          is_imm,
    output logic          page_cross
);
    amode_t          mode_q;
    logic [AW-1:0]   opnd_q;
    logic [DW-1:0]   x_q, y_q;
    logic [AW-1:0]   ptr_q;
    logic            load, cap_lo, cap_hi, use_hi, done_i;
    logic [AW-1:0]   rd_addr0, rd_addr1, ea_c;
    logic            cross_c, imm_c;

    eag_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ptr_mode  (needs_ptr(mode)),
        .mem_valid (mem_valid),
        .load      (load),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .mem_req   (mem_req),
        .use_hi    (use_hi),
        .done      (done_i)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= AM_IMM;
            opnd_q <= '0;
            x_q    <= '0;
            y_q    <= '0;
            ptr_q  <= '0;
        end else begin
            if (load) begin
                mode_q <= amode_t'(mode);
                opnd_q <= {opnd_hi, opnd_lo};
                x_q    <= idx_x;
                y_q    <= idx_y;
            end
            if (cap_lo) ptr_q[DW-1:0]  <= mem_rdata;
            if (cap_hi) ptr_q[AW-1:DW] <= mem_rdata;
        end
    end

    eag_addr_calc u_calc (
        .mode_q   (mode_q),
        .opnd_q   (opnd_q),
        .x_q      (x_q),
        .y_q      (y_q),
        .ptr_q    (ptr_q),
        .rd_addr0 (rd_addr0),
        .rd_addr1 (rd_addr1),
        .ea_c     (ea_c),
        .cross_c  (cross_c),
        .imm_c    (imm_c)
    );

    always_comb begin
        mem_addr   = use_hi ? rd_addr1 : rd_addr0;
        done       = done_i;
        ea         = done_i ? ea_c : '0;
        is_imm     = done_i & imm_c;
        page_cross = done_i & cross_c;
    end
endmodule

// File: rtl/eag_checks.sv
module eag_checks
    import eag_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        mem_req,
    input logic        mem_valid,
    input logic [15:0] mem_addr,
    input logic [15:0] ea,
    input logic        is_imm,
    input logic        page_cross,
    input amode_t      mode_q
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R9
    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R9
    AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_imm || page_cross) |-> done); // R10
    AST_IMM_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        is_imm |-> (ea == 16'h0000)); // R1
    AST_ZPG_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == AM_ZPG) |-> (ea[15:8] == 8'h00)); // R3
    AST_ZPIDX_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == AM_ZPX || mode_q == AM_ZPY)) |-> (ea[15:8] == 8'h00 && !page_cross)); // R5
    AST_PTR_IN_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mode_q == AM_PRE) |-> (mem_addr[15:8] == 8'h00)); // R6
    AST_POST_PTR_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mode_q == AM_POST) |-> (mem_addr[15:8] == 8'h00)); // R7
    AST_CROSS_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        page_cross |-> (mode_q == AM_ABX || mode_q == AM_ABY || mode_q == AM_POST)); // R4
endmodule

bind eag_unit eag_checks u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .mem_req    (mem_req),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .ea         (ea),
    .is_imm     (is_imm),
    .page_cross (page_cross),
    .mode_q     (mode_q)
);

// File: tb/sim_eag_unit.sv
`timescale 1ns/1ps
module sim_eag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [7:0]  opnd_lo = 8'h00, opnd_hi = 8'h00, idx_x = 8'h00, idx_y = 8'h00;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_valid = 1'b0;
    logic        done;
    logic [15:0] ea;
    logic        is_imm, page_cross;

    int checks = 0;
    int fails = 0;
    bit ended = 0;
    int lat_cfg = 0;
    int wcnt = 0;
    int rd_n = 0;
    logic [15:0] rd_log [0:15];

    always #4 clk = ~clk;

    eag_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_valid(mem_valid), .done(done), .ea(ea), .is_imm(is_imm),
        .page_cross(page_cross)
    );

    function automatic logic [7:0] mfn(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(negedge clk) begin
        if (mem_req && wcnt >= lat_cfg) begin
            mem_valid <= 1'b1;
            mem_rdata <= mfn(mem_addr);
            wcnt <= 0;
        end else begin
            mem_valid <= 1'b0;
            wcnt <= mem_req ? wcnt + 1 : 0;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_valid) begin
            rd_log[rd_n % 16] = mem_addr;
            rd_n = rd_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [15:0] r_ea;
    logic        r_imm, r_cross;
    int          r_cyc, r_base;

    task automatic run_op(input logic [3:0] m, input logic [15:0] op,
                          input logic [7:0] x, input logic [7:0] y, input int lat);
        @(negedge clk);
        mode = m; opnd_lo = op[7:0]; opnd_hi = op[15:8]; idx_x = x; idx_y = y;
        lat_cfg = lat; r_base = rd_n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_cyc = 1;
        while (!done && r_cyc < 100) begin
            @(negedge clk);
            r_cyc++;
        end
        r_ea = ea; r_imm = is_imm; r_cross = page_cross;
        @(negedge clk);
        chk("R10 done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R11 done in reset", {31'd0, done}, 32'd0);
        chk("R11 req in reset", {31'd0, mem_req}, 32'd0);
        chk("R11 flags in reset", {30'd0, is_imm, page_cross}, 32'd0);
    endtask

    task automatic t_imm();
        run_op(4'd0, 16'h1207, 8'h03, 8'h04, 0);
        chk("R1 latency", r_cyc, 1);
        chk("R1 is_imm", {31'd0, r_imm}, 32'd1);
        chk("R1 ea zero", {16'd0, r_ea}, 32'h0);
        chk("R1 no reads", rd_n - r_base, 0);
    endtask

    task automatic t_abs();
        run_op(4'd1, 16'h3010, 8'h12, 8'h00, 0);
        chk("R2 ea", {16'd0, r_ea}, 32'h3010);
        chk("R2 latency", r_cyc, 1);
        run_op(4'd13, 16'hBEEF, 8'h12, 8'h00, 0);
        chk("R2 reserved code as absolute", {16'd0, r_ea}, 32'hBEEF);
    endtask

    task automatic t_zpg();
        run_op(4'd2, 16'h7780, 8'h00, 8'h00, 0);
        chk("R3 ea", {16'd0, r_ea}, 32'h0080);
        chk("R3 imm flag low", {31'd0, r_imm}, 32'd0);
    endtask

    task automatic t_absidx();
        run_op(4'd3, 16'h3120, 8'h12, 8'hEE, 0);
        chk("R4 abs+X ea", {16'd0, r_ea}, 32'h3132);
        chk("R4 abs+X no cross", {31'd0, r_cross}, 32'd0);
        run_op(4'd3, 16'h31F0, 8'h20, 8'h00, 0);
        chk("R4 abs+X cross ea", {16'd0, r_ea}, 32'h3210);
        chk("R4 abs+X cross", {31'd0, r_cross}, 32'd1);
        run_op(4'd4, 16'hFFF0, 8'h01, 8'h20, 0);
        chk("R4 abs+Y wrap ea", {16'd0, r_ea}, 32'h0010);
        chk("R4 abs+Y wrap cross", {31'd0, r_cross}, 32'd1);
    endtask

    task automatic t_zpidx();
        run_op(4'd5, 16'h4480, 8'h12, 8'h40, 0);
        chk("R5 zp+X ea", {16'd0, r_ea}, 32'h0092);
        run_op(4'd5, 16'h44F0, 8'h20, 8'h00, 0);
        chk("R5 zp+X wrap ea", {16'd0, r_ea}, 32'h0010);
        chk("R5 zp+X no cross", {31'd0, r_cross}, 32'd0);
        run_op(4'd6, 16'h0082, 8'h99, 8'h05, 0);
        chk("R5 zp+Y ea", {16'd0, r_ea}, 32'h0087);
    endtask

    task automatic t_pre();
        logic [15:0] a0, a1;
        run_op(4'd7, 16'h5570, 8'h05, 8'h33, 0);
        a0 = 16'h0075; a1 = 16'h0076;
        chk("R6 reads", rd_n - r_base, 2);
        chk("R6 first addr", {16'd0, rd_log[r_base % 16]}, {16'd0, a0});
        chk("R6 ea", {16'd0, r_ea}, {16'd0, mfn(a1), mfn(a0)});
        chk("R9 latency lat0", r_cyc, 3);
        run_op(4'd7, 16'h00FE, 8'h01, 8'h00, 1);
        chk("R6 wrap first addr", {16'd0, rd_log[r_base % 16]}, 32'h00FF);
        chk("R6 wrap second addr", {16'd0, rd_log[(r_base + 1) % 16]}, 32'h0000);
        chk("R6 wrap ea", {16'd0, r_ea}, {16'd0, mfn(16'h0000), mfn(16'h00FF)});
        chk("R9 latency lat1", r_cyc, 5);
    endtask

    task automatic t_post();
        logic [15:0] p, e;
        for (int k = 0; k < 3; k++) begin
            logic [7:0] zl, yy;
            zl = (k == 2) ? 8'hFF : 8'h70 + 8'(k * 9);
            yy = (k == 0) ? 8'h10 : 8'hF3;
            run_op(4'd8, {8'h66, zl}, 8'h44, yy, k);
            p = {mfn({8'h00, 8'(zl + 8'd1)}), mfn({8'h00, zl})};
            e = p + {8'h00, yy};
            chk("R7 first addr", {16'd0, rd_log[r_base % 16]}, {24'd0, zl});
            chk("R7 second addr", {16'd0, rd_log[(r_base + 1) % 16]}, {24'd0, 8'(zl + 8'd1)});
            chk("R7 ea", {16'd0, r_ea}, {16'd0, e});
            chk("R7 cross", {31'd0, r_cross}, {31'd0, (e[15:8] != p[15:8])});
            chk("R9 latency", r_cyc, 2 * k + 3);
        end
    endtask

    task automatic t_ind();
        run_op(4'd9, 16'h28FF, 8'h10, 8'h20, 2);
        chk("R8 first addr", {16'd0, rd_log[r_base % 16]}, 32'h28FF);
        chk("R8 second addr", {16'd0, rd_log[(r_base + 1) % 16]}, 32'h2900);
        chk("R8 ea", {16'd0, r_ea}, {16'd0, mfn(16'h2900), mfn(16'h28FF)});
        chk("R8 cross low", {31'd0, r_cross}, 32'd0);
    endtask

    task automatic t_busy();
        int c;
        @(negedge clk);
        mode = 4'd7; opnd_lo = 8'h20; opnd_hi = 8'h00; idx_x = 8'h02; idx_y = 8'h00;
        lat_cfg = 2; r_base = rd_n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        mode = 4'd0; opnd_lo = 8'h99; idx_x = 8'h50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c = 0;
        while (!done && c < 100) begin
            @(negedge clk);
            c++;
        end
        chk("R10 busy start ignored ea", {16'd0, ea}, {16'd0, mfn(16'h0023), mfn(16'h0022)});
        chk("R10 busy start no imm", {31'd0, is_imm}, 32'd0);
        chk("R10 busy reads", rd_n - r_base, 2);
        @(negedge clk);
        chk("R10 no second done", {31'd0, done}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R10 stays idle", {30'd0, done, mem_req}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_imm();
        t_abs();
        t_zpg();
        t_absidx();
        t_zpidx();
        t_pre();
        t_post();
        t_ind();
        t_busy();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule